// File: doc/BRIEF.md
# Per-Load Runahead Entry Gate

This block decides, per static load instruction, whether a long-latency cache miss from that load should start a speculative runahead period. It holds a small direct-mapped table of saturating confidence counters. The table is indexed by a slice of the load's program counter, and no tags are stored. When the core is about to enter runahead mode on a miss, it presents the load PC on the lookup port. The block answers in the same cycle with a grant and the current counter level.

When a runahead period ends, the core reports the PC of the load that caused it. It also reports whether the period turned out useful, which means it produced at least one new L2 miss. A useful period strengthens that load's counter and a useless period weakens it. Loads whose recent periods produced nothing are therefore kept out of runahead mode. Loads that have never been seen start in a weakly confident state and are allowed in.

Top module: `runahead_gate`

## Requirements
- R1: While reset is asserted and after it is released, every counter holds 2 (weakly useful), so a lookup of any PC returns `lk_ctr` = 2 and a grant.
- R2: The table has 64 entries selected by PC bits [7:2]; PC bits outside that slice have no effect, so two PCs that agree in bits [7:2] share one counter.
- R3: An update with `up_useful` = 1 raises the selected counter by one at the next clock edge, and the counter stays at 3 once it is there.
- R4: An update with `up_useful` = 0 lowers the selected counter by one at the next clock edge, and the counter stays at 0 once it is there.
- R5: `lk_grant` is 1 exactly when `lk_valid` is 1 and the counter for `lk_pc` is 2 or 3; counter values 0 and 1 deny entry.
- R6: When a lookup and an update select the same entry in the same cycle, the lookup reports the value held before that update, and the new value is visible from the next cycle.
- R7: With `up_valid` = 0, the update inputs change no counter.
- R8: An update changes only the entry its PC selects; every other entry keeps its value.
- R9: With `lk_valid` = 0, `lk_grant` is 0 whatever the counter holds, while `lk_ctr` still shows the counter for `lk_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A runahead entry request is presented |
| lk_pc | input | 32 | PC of the load that wants to start runahead |
| lk_grant | output | 1 | Runahead entry permitted for this load |
| lk_ctr | output | 2 | Counter level currently held for `lk_pc` |
| up_valid | input | 1 | A runahead period has just finished |
| up_pc | input | 32 | PC of the load that caused the finished period |
| up_useful | input | 1 | 1 if the period generated at least one L2 miss |

## Verification
The lookup answer is combinational, so `lk_grant` and `lk_ctr` are due in the same cycle the lookup PC is driven. An update takes effect at the next rising edge and can first be seen in the cycle after it is presented. The bench drives every input just after a falling edge and compares both outputs with a behavioural model of the 64 counters a nanosecond later, before the next rising edge. It advances the model only after that edge. This ordering is what exposes the old-value rule for a lookup and an update that select the same entry in one cycle.

// File: rtl/rup_pkg.sv
package rup_pkg;
   // Default geometry of the usefulness table
   localparam int unsigned RUP_PC_W    = 32;
   localparam int unsigned RUP_IDX_W   = 6;
   localparam int unsigned RUP_IDX_LSB = 2;
   localparam int unsigned RUP_CTR_W   = 2;
   localparam int unsigned RUP_INIT    = 2;
   localparam int unsigned RUP_GRANT   = 2;

   typedef enum logic [1:0] {
      CONF_STRONG_NO  = 2'd0,
      CONF_WEAK_NO    = 2'd1,
      CONF_WEAK_YES   = 2'd2,
      CONF_STRONG_YES = 2'd3
   } rup_conf_e;
endpackage

// File: rtl/rup_index.sv
module rup_index #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned IDX_LSB = 2,
   parameter int unsigned IDX_W   = 6
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);
   // Only the index slice matters; the remaining bits alias freely
   logic [PC_W-1:0] pc_unused;
   assign pc_unused = pc;
   assign idx = pc[IDX_LSB +: IDX_W];
endmodule

// File: rtl/rup_decode.sv
module rup_decode #(
   parameter int unsigned IDX_W = 6,
   localparam int unsigned ENTRIES = 1 << IDX_W
) (
   input  logic               en,
   input  logic [IDX_W-1:0]   idx,
   output logic [ENTRIES-1:0] sel
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_sel
      assign sel[g] = en && (idx == IDX_W'(g));
   end
endmodule

// File: rtl/rup_sat_ctr.sv
module rup_sat_ctr #(
   parameter int unsigned CTR_W = 2,
   parameter int unsigned INIT  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             inc,
   output logic [CTR_W-1:0] q
);
   localparam logic [CTR_W-1:0] TOP = '1;
   localparam logic [CTR_W-1:0] BOT = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= INIT[CTR_W-1:0];
      end else if (en) begin
         if (inc && q != TOP) q <= q + 1'b1;
         else if (!inc && q != BOT) q <= q - 1'b1;
      end
   end

   p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && inc && q != TOP) |=> (q == $past(q) + 1'b1));
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && inc && q == TOP) |=> (q == TOP));
   p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !inc && q != BOT) |=> (q == $past(q) - 1'b1));
   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !inc && q == BOT) |=> (q == BOT));
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en) |=> $stable(q));
endmodule

// File: rtl/runahead_gate.sv
module runahead_gate
   import rup_pkg::*;
#(
   parameter int unsigned PC_W      = RUP_PC_W,
   parameter int unsigned IDX_LSB   = RUP_IDX_LSB,
   parameter int unsigned IDX_W     = RUP_IDX_W,
   parameter int unsigned CTR_W     = RUP_CTR_W,
   parameter int unsigned INIT      = RUP_INIT,
   parameter int unsigned GRANT_MIN = RUP_GRANT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [PC_W-1:0]  lk_pc,
   output logic             lk_grant,
   output logic [CTR_W-1:0] lk_ctr,
   input  logic             up_valid,
   input  logic [PC_W-1:0]  up_pc,
   input  logic             up_useful
);
   localparam int unsigned ENTRIES = 1 << IDX_W;
   localparam logic [CTR_W-1:0] THRESH = GRANT_MIN[CTR_W-1:0];

   if (IDX_LSB + IDX_W > PC_W) begin : g_bad_slice
      $error("index slice exceeds PC width");
   end
   if (INIT >= (1 << CTR_W) || GRANT_MIN >= (1 << CTR_W)) begin : g_bad_ctr
      $error("counter init or threshold does not fit the counter");
   end

   logic [IDX_W-1:0]   lk_idx;
   logic [IDX_W-1:0]   up_idx;
   logic [ENTRIES-1:0] wr_sel;
   logic [CTR_W-1:0]   ctr_q [ENTRIES];

   rup_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) i_lk_index (
      .pc(lk_pc), .idx(lk_idx));
   rup_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) i_up_index (
      .pc(up_pc), .idx(up_idx));
   rup_decode #(.IDX_W(IDX_W)) i_decode (
      .en(up_valid), .idx(up_idx), .sel(wr_sel));

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      rup_sat_ctr #(.CTR_W(CTR_W), .INIT(INIT)) i_ctr (
         .clk(clk), .rst_n(rst_n), .en(wr_sel[g]), .inc(up_useful),
         .q(ctr_q[g]));
   end

   // Read side sees the registered table, i.e. the value before any
   // update presented in the same cycle
   assign lk_ctr   = ctr_q[lk_idx];
   assign lk_grant = lk_valid && (lk_ctr >= THRESH);
endmodule

// File: tb/test_runahead_gate.sv
module test_runahead_gate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_grant;
   logic [1:0]  lk_ctr;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic        up_useful = 1'b0;

   int model [64];
   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   runahead_gate i_runahead_gate (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
      .lk_grant(lk_grant), .lk_ctr(lk_ctr), .up_valid(up_valid),
      .up_pc(up_pc), .up_useful(up_useful));

   function automatic int slot(input logic [31:0] pc);
      return int'(pc[7:2]);
   endfunction

   // One cycle: drive after the falling edge, compare, then let the edge act
   task automatic step(input string req, input bit lv, input logic [31:0] lpc,
                       input bit uv, input logic [31:0] upc, input bit uu);
      int exp_c;
      bit exp_g;
      @(negedge clk);
      lk_valid = lv; lk_pc = lpc; up_valid = uv; up_pc = upc; up_useful = uu;
      #1;
      exp_c = model[slot(lpc)];
      exp_g = lv && (exp_c >= 2);
      tests++;
      if (int'(lk_ctr) != exp_c || lk_grant != exp_g) begin
         fails++;
         $display("FAIL %s: ctr=%0d grant=%0d, expected ctr=%0d grant=%0d",
                  req, lk_ctr, lk_grant, exp_c, exp_g);
      end
      @(posedge clk);
      if (rst_n && uv) begin
         if (uu && model[slot(upc)] < 3) model[slot(upc)]++;
         else if (!uu && model[slot(upc)] > 0) model[slot(upc)]--;
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) model[i] = 2;
      // R1: reset value seen during reset, even with an update pending
      step("R1", 1, 32'h0000_0040, 1, 32'h0000_0040, 0);
      step("R1", 1, 32'h1234_56FC, 0, 32'h0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) step("R1", 1, 32'h100 + 32'(i * 4), 0, 32'h0, 0);
      // R3: climb and saturate at 3
      for (int i = 0; i < 3; i++) step("R3", 1, 32'h0000_0010, 1, 32'h0000_0010, 1);
      step("R3", 1, 32'h0000_0010, 0, 32'h0, 0);
      // R4: fall and saturate at 0
      for (int i = 0; i < 4; i++) step("R4", 1, 32'h0000_0020, 1, 32'h0000_0020, 0);
      step("R4", 1, 32'h0000_0020, 0, 32'h0, 0);
      // R5: denial at 0 and 1, grant restored at 2
      step("R5", 1, 32'h0000_0020, 1, 32'h0000_0020, 1);
      step("R5", 1, 32'h0000_0020, 1, 32'h0000_0020, 1);
      step("R5", 1, 32'h0000_0020, 0, 32'h0, 0);
      // R6: same-cycle lookup/update returns the old value
      step("R6", 1, 32'h0000_0030, 1, 32'h0000_0030, 0);
      step("R6", 1, 32'h0000_0030, 1, 32'h0000_0030, 0);
      step("R6", 1, 32'h0000_0030, 0, 32'h0, 0);
      // R2: aliasing through bits outside [7:2]
      step("R2", 1, 32'hFFFF_FF44, 1, 32'h0000_1044, 0);
      step("R2", 1, 32'hFFFF_FF44, 1, 32'h0000_1044, 0);
      step("R2", 1, 32'h8000_0044, 0, 32'h0, 0);
      // R7: disabled update leaves the counter alone
      step("R7", 1, 32'h0000_0050, 0, 32'h0000_0050, 1);
      step("R7", 1, 32'h0000_0050, 0, 32'h0000_0050, 0);
      step("R7", 1, 32'h0000_0050, 0, 32'h0, 0);
      // R8: neighbours of a trained entry are untouched
      step("R8", 1, 32'h0000_004C, 0, 32'h0, 0);
      step("R8", 1, 32'h0000_003C, 0, 32'h0, 0);
      // R9: no grant without a request, counter still visible
      step("R9", 0, 32'h0000_0010, 0, 32'h0, 0);
      step("R9", 0, 32'h0000_0044, 0, 32'h0, 0);
      // R5, R6, R8: random traffic checked against the model
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] a, b;
         a = $urandom(); b = $urandom();
         if (($urandom() & 3) == 0) b = a;
         step("R5", bit'($urandom() & 1), a, bit'(($urandom() % 3) != 0), b,
              bit'($urandom() & 1));
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule